// File: doc/BRIEF.md
# Serial EEPROM Bus Slave Controller

This block is the bus-facing protocol engine of a 512-byte serial memory on a two-wire bus. It samples already-filtered clock and data lines in the system clock domain and detects START and STOP conditions. It checks the device address byte against a fixed four-bit family code and against two strap pins. The address byte also carries a memory-half select bit, which the controller latches as bit 8 of its 9-bit address pointer. A following word address byte supplies bits 7 to 0.

Received data bytes are acknowledged and handed, one strobe per byte, to a separate page-write unit together with their 9-bit address. Reads come from an external 512x8 synchronous array with one cycle of latency. Three read forms are served: a single-byte read, a random read (word address written, then a repeated START and a read address byte) and a sequential read that lasts as long as the master keeps acknowledging. The slave only pulls the data line low, through `sda_oe`. It never stretches the clock.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: While reset is asserted and directly after it, `sda_oe` and `wr_valid` are 0.
- R2: An address byte whose bits 7..4 are 1010, bit 3 equals `strap_hi` and bit 2 equals `strap_lo` is acknowledged: SDA is held low for the whole ninth clock high phase. All bytes are sent MSB first.
- R3: An address byte that fails the match is not acknowledged. The slave then neither drives SDA nor emits `wr_valid` until the next START.
- R4: In a write, address bit 0 = 0, address bit 1 becomes pointer bit 8 and the word address byte becomes pointer bits 7..0. Each data byte produces a one-cycle `wr_valid`, issued while SCL is low, with `wr_addr` = pointer and `wr_data` = the byte.
- R5: Every data byte of a write is acknowledged. The pointer advances by one per byte and wraps from 511 to 0.
- R6: A random read (word address write, repeated START, address byte with bit 0 = 1) returns the array byte at {page bit, word address} as its first byte.
- R7: While the master acknowledges, the next byte read is the one at pointer+1, wrapping from 511 to 0.
- R8: After the master does not acknowledge a read byte, the slave releases SDA and leaves it released on all following clocks until a START.
- R9: SDA changes caused by the slave occur only while SCL is low.
- R10: A STOP inside a byte aborts it, so no partial byte reaches the write port. A START inside a transfer restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Filtered serial clock line |
| sda_i | input | 1 | Filtered serial data line (bus level) |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_hi | input | 1 | Strap matched against address bit 3 |
| strap_lo | input | 1 | Strap matched against address bit 2 |
| mem_addr | output | 9 | Array read address (current pointer) |
| mem_rd_en | output | 1 | Array read enable |
| mem_rdata | input | 8 | Array read data, one cycle after address |
| wr_valid | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | 9 | Address of the received byte |
| wr_data | output | 8 | Received data byte |

## Verification
A bit counter that is off by one shows at once at the ports. The acknowledge falls on the wrong SCL pulse, or read data appears shifted by one bit in the very first byte after the address. A wrong pointer or page bit gives the wrong array byte on the first read, or a wrong `wr_addr` on the first data strobe. A pointer that wraps badly becomes visible only when a transfer crosses address 511. A state that fails to return to idle after a NACK, a mismatch or an abort shows as SDA being driven on the clocks that follow. That is within one byte time.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       strap_hi,
  input  logic       strap_lo,
  output logic [8:0] mem_addr,
  output logic       mem_rd_en,
  input  logic [7:0] mem_rdata,
  output logic       wr_valid,
  output logic [8:0] wr_addr,
  output logic [7:0] wr_data
);
  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WADR, S_WDAT, S_RDAT} st_t;

  st_t        st;
  logic       scl_q, sda_q, mack;
  logic [3:0] bitcnt;
  logic [7:0] sr;
  logic [6:0] tx;
  logic [8:0] ptr;

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire start_c  = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  wire dev_hit  = (sr[7:4] == DEV_CODE) && (sr[3] == strap_hi) && (sr[2] == strap_lo);
  wire load_rd  = ((st == S_DEV) && sr[0]) || ((st == S_RDAT) && mack);

  assign mem_addr  = ptr;
  assign mem_rd_en = (st == S_DEV) || (st == S_RDAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      mack     <= 1'b0;
      bitcnt   <= '0;
      sr       <= '0;
      tx       <= '0;
      ptr      <= '0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      scl_q    <= scl_i;
      sda_q    <= sda_i;
      wr_valid <= 1'b0;
      if (start_c) begin
        st     <= S_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          bitcnt <= bitcnt + 4'd1;
          if (bitcnt < 4'd8) sr <= {sr[6:0], sda_i};
          else               mack <= ~sda_i;
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            case (st)
              S_DEV:
                if (dev_hit) begin
                  sda_oe <= 1'b1;
                  ptr[8] <= sr[1];
                end else begin
                  st <= S_IDLE;
                end
              S_WADR: begin
                sda_oe   <= 1'b1;
                ptr[7:0] <= sr;
              end
              S_WDAT: begin
                sda_oe   <= 1'b1;
                wr_valid <= 1'b1;
                wr_addr  <= ptr;
                wr_data  <= sr;
                ptr      <= ptr + 9'd1;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            if (load_rd) begin
              st     <= S_RDAT;
              tx     <= mem_rdata[6:0];
              sda_oe <= ~mem_rdata[7];
              ptr    <= ptr + 9'd1;
            end else begin
              sda_oe <= 1'b0;
              case (st)
                S_DEV:   st <= S_WADR;
                S_WADR:  st <= S_WDAT;
                S_RDAT:  st <= S_IDLE;
                default: st <= st;
              endcase
            end
          end else if (st == S_RDAT) begin
            sda_oe <= ~tx[6];
            tx     <= {tx[5:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
module i2c_eeprom_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic wr_valid
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!sda_oe && !wr_valid)); // R1
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_i)); // R9
  AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> sda_oe); // R5
  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R4
  AST_WRITE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !scl_i); // R4
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .wr_valid(wr_valid)
);

// File: tb/i2c_eeprom_slave_test.sv
module i2c_eeprom_slave_test;
  localparam bit HS = 1'b1;
  localparam bit LS = 1'b0;

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, mem_rd_en, wr_valid;
  logic [8:0] mem_addr, wr_addr;
  logic [7:0] mem_q, wr_data;
  int total = 0, bad = 0, wr_cnt = 0;
  logic [8:0] last_addr;
  logic [7:0] last_data;

  wire sda_line = m_sda & ~sda_oe;

  always #4 clk = ~clk;

  i2c_eeprom_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_hi(HS), .strap_lo(LS), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .mem_rdata(mem_q), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [7:0] memv(input logic [8:0] a);
    return 8'((a * 37) + (a >> 8) * 91 + 11);
  endfunction

  function automatic logic [7:0] dev_byte(input bit h, input bit l, input bit pg, input bit rd);
    return {4'b1010, h, l, pg, rd};
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_q <= memv(mem_addr);

  always @(posedge clk) if (wr_valid) begin
    wr_cnt <= wr_cnt + 1;
    last_addr <= wr_addr;
    last_data <= wr_data;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_sda = 1'b1; q(); m_scl = 1'b1; q();
    ack = ~sda_line;
    q(); m_scl = 1'b0; q();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b, output bit steady);
    steady = 1'b1;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); m_scl = 1'b1; q();
      b[i] = sda_line;
      q();
      if (sda_line != b[i]) steady = 1'b0;
      m_scl = 1'b0;
    end
    q(); m_sda = ~give_ack; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q(); m_sda = 1'b1;
  endtask

  task automatic do_write(input bit pg, input logic [7:0] w, input int n);
    bit ack;
    logic [8:0] a;
    logic [7:0] d;
    bus_start();
    send_byte(dev_byte(HS, LS, pg, 1'b0), ack); chk(ack, "R2 write address ack", ack, 1);
    send_byte(w, ack); chk(ack, "R5 word address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      a = 9'({pg, w} + i);
      d = 8'($urandom);
      send_byte(d, ack); chk(ack, "R5 data ack", ack, 1);
      chk(last_addr == a, "R4 wr_addr", last_addr, a);
      chk(last_data == d, "R4 wr_data", last_data, d);
    end
    bus_stop();
  endtask

  task automatic do_read(input bit pg, input logic [7:0] w, input int n, input bit tail);
    bit ack, st;
    logic [7:0] b;
    logic [8:0] a;
    bus_start();
    send_byte(dev_byte(HS, LS, pg, 1'b0), ack); chk(ack, "R2 address ack", ack, 1);
    send_byte(w, ack); chk(ack, "R6 word address ack", ack, 1);
    bus_start();
    send_byte(dev_byte(HS, LS, pg, 1'b1), ack); chk(ack, "R6 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      a = 9'({pg, w} + i);
      recv_byte(i < n - 1, b, st);
      chk(b == memv(a), i == 0 ? "R6 first read byte" : "R7 sequential byte", b, memv(a));
      chk(st, "R9 SDA steady while SCL high", st, 1);
    end
    if (tail) begin
      recv_byte(1'b0, b, st);
      chk(b == 8'hff, "R8 released after NACK", b, 8'hff);
    end
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ack;
    int n0;
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    chk(sda_oe == 1'b0 && wr_valid == 1'b0, "R1 reset outputs", {sda_oe, wr_valid}, 0);
    rst_n = 1'b1;
    q();
    chk(sda_oe == 1'b0 && wr_valid == 1'b0, "R1 after reset", {sda_oe, wr_valid}, 0);

    do_write(1'b0, 8'h10, 3);
    do_write(1'b1, 8'hff, 2);
    do_read(1'b1, 8'hfe, 4, 1'b0);
    do_read(1'b0, 8'hff, 2, 1'b1);

    for (int k = 0; k < 8; k++) begin
      if ($urandom % 2) do_write(1'($urandom), 8'($urandom), 1 + $urandom % 4);
      else              do_read(1'($urandom), 8'($urandom), 1 + $urandom % 5, 1'($urandom));
    end

    n0 = wr_cnt;
    bus_start();
    send_byte(dev_byte(~HS, LS, 1'b0, 1'b0), ack); chk(!ack, "R3 strap mismatch no ack", ack, 0);
    send_byte(8'h00, ack); chk(!ack, "R3 silent after mismatch", ack, 0);
    send_byte(8'h55, ack); chk(!ack && wr_cnt == n0, "R3 no write after mismatch", wr_cnt, n0);
    bus_stop();
    bus_start();
    send_byte(8'hb0 | {HS, LS, 2'b00}, ack); chk(!ack, "R3 code mismatch no ack", ack, 0);
    bus_stop();

    bus_start();
    send_byte(dev_byte(HS, LS, 1'b0, 1'b0), ack);
    send_byte(8'h40, ack);
    send_bits(8'hA5, 4);
    bus_stop();
    chk(wr_cnt == n0, "R10 stop mid-byte drops data", wr_cnt, n0);

    bus_start();
    send_bits(dev_byte(HS, LS, 1'b0, 1'b0), 3);
    bus_start();
    send_byte(dev_byte(HS, LS, 1'b1, 1'b1), ack); chk(ack, "R10 restart address ack", ack, 1);
    bus_stop();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule